// File: doc/BRIEF.md
# Serial ADC Conversion and Readout Model

This block stands in for the digital face of a 12-bit converter with a three-wire serial output. It lets the controller that will drive such a converter be exercised in simulation or on a prototype without any analog hardware. A parallel sample input supplies the word that the next conversion returns. The select, serial clock and sample inputs are all brought into one system clock domain through two-flop synchronizers.

Pulling the active-low select low starts a conversion. The model then waits a programmable number of system clock cycles, which stands for the conversion time (about 7.5 µs in a real part). At the end of that wait it drives its serial data line high. That rising edge is the end-of-conversion flag. From there, each falling edge of the serial clock presents the next result bit, most significant first. The host therefore samples on rising edges. Once the last bit has gone out, further clocks shift out zeros. Raising select at any point returns the model to idle, and it drives the data line low there in place of high impedance.

Top module: `sadc_emu`

## Requirements
- R1: While synchronized select is high, the model is idle, sdo_out is 0 and the conversion timer is held cleared. After reset, sdo_out is 0.
- R2: A high-to-low transition of synchronized select captures the synchronized sample word, and that word is the result read out in the frame.
- R3: During conversion sdo_out stays 0. Exactly CONV_CYCLES system cycles after conversion starts, sdo_out goes to 1 and remains 1 until the first serial clock falling edge.
- R4: Serial clock edges that occur during conversion change neither the conversion duration nor the result.
- R5: After the end-of-conversion flag, the k-th serial clock falling edge (k = 1..12) presents result bit 12-k on sdo_out, so bit 11 comes first and bit 0 last.
- R6: In the readout phase, sdo_out changes only in response to a serial clock falling edge, so it is stable at each serial clock rising edge.
- R7: Serial clock falling edges after bit 0 drive sdo_out to 0, and the model stays in readout until select rises.
- R8: Raising select during conversion or mid-readout aborts the frame: sdo_out goes to 0, no end-of-conversion flag follows, and the next select fall starts a fresh conversion.
- R9: When cs_n_in is driven low half a cycle before a clock edge, sdo_out is first seen high after the (CONV_CYCLES+3)-th falling clock edge. The 3 extra cycles come from two synchronizer stages and one edge-detect stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_in | input | 1 | Active-low chip select from the host |
| sclk_in | input | 1 | Serial clock from the host, idle low |
| sample_in | input | 12 | Word returned by the next conversion |
| sdo_out | output | 1 | Serial data, with end-of-conversion flag |

## Verification
The bench builds the model with CONV_CYCLES set to 12 instead of the default 150. This lets many conversions fit in a short run and puts the end-of-conversion boundary only a dozen cycles after each select fall. The serial clock half-period is 4 system cycles, just above the 3-cycle input latency, so every bit is checked at the tightest spacing the synchronizers allow. A behavioural model in the bench predicts sdo_out on every cycle. Select is also pulled early both during conversion and partway through readout.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int WORD_W = 12;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CONV = 2'd1,
        PH_READ = 2'd2
    } phase_t;

    typedef struct packed {
        logic cs_n;
        logic sclk;
    } ctl_t;

    localparam ctl_t CTL_RST = '{cs_n: 1'b1, sclk: 1'b0};

    function automatic int cnt_width(input int cycles);
        return (cycles > 1) ? $clog2(cycles) : 1;
    endfunction

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);

    logic [W-1:0] meta_q;
    logic [W-1:0] lvl_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            lvl_q  <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            meta_q <= d_in;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign lvl  = lvl_q;
    assign prev = prev_q;

endmodule

// File: rtl/sadc_timer.sv
module sadc_timer #(
    parameter int CONV_CYCLES = 150
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    import sadc_pkg::*;

    localparam int               CNT_W = cnt_width(CONV_CYCLES);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(CONV_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // cleared whenever not converting
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == LAST);

endmodule

// File: rtl/sadc_shifter.sv
module sadc_shifter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] word_in,
    output logic         msb
);

    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= word_in;
        end else if (shift) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
        end
    end

    assign msb = sh_q[W-1];

endmodule

// File: rtl/sadc_emu.sv
module sadc_emu #(
    parameter int CONV_CYCLES = 150
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cs_n_in,
    input  logic                         sclk_in,
    input  logic [sadc_pkg::WORD_W-1:0]  sample_in,
    output logic                         sdo_out
);
    import sadc_pkg::*;

    ctl_t              ctl_raw, ctl_lvl, ctl_prev;
    logic [WORD_W-1:0] smp_lvl, smp_prev;
    phase_t            phase_q;
    logic              sdo_q;
    logic              cs_lvl, cs_fall, sclk_fall;
    logic              tmr_run, tmr_done;
    logic              shf_load, shf_shift, shf_msb;

    assign ctl_raw = '{cs_n: cs_n_in, sclk: sclk_in};

    sadc_sync #(.W($bits(ctl_t)), .RST_VAL(CTL_RST)) u_ctl_sync (
        .clk  (clk),
        .rst  (rst),
        .d_in (ctl_raw),
        .lvl  (ctl_lvl),
        .prev (ctl_prev)
    );

    sadc_sync #(.W(WORD_W), .RST_VAL('0)) u_smp_sync (
        .clk  (clk),
        .rst  (rst),
        .d_in (sample_in),
        .lvl  (smp_lvl),
        .prev (smp_prev)
    );

    assign cs_lvl    = ctl_lvl.cs_n;
    assign cs_fall   = ctl_prev.cs_n && !ctl_lvl.cs_n;
    assign sclk_fall = ctl_prev.sclk && !ctl_lvl.sclk;

    assign tmr_run   = (phase_q == PH_CONV) && !cs_lvl;
    assign shf_load  = (phase_q == PH_IDLE) && cs_fall;
    assign shf_shift = (phase_q == PH_READ) && sclk_fall && !cs_lvl;

    sadc_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (tmr_run),
        .done (tmr_done)
    );

    sadc_shifter #(.W(WORD_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (shf_load),
        .shift   (shf_shift),
        .word_in (smp_lvl),
        .msb     (shf_msb)
    );

    always_ff @(posedge clk) begin
        if (rst || cs_lvl) begin
            phase_q <= PH_IDLE;
            sdo_q   <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    sdo_q <= 1'b0;
                    if (cs_fall) phase_q <= PH_CONV;
                end
                PH_CONV: begin
                    if (tmr_done) begin
                        phase_q <= PH_READ;
                        sdo_q   <= 1'b1;
                    end
                end
                PH_READ: begin
                    if (sclk_fall) sdo_q <= shf_msb;
                end
                default: begin
                    phase_q <= PH_IDLE;
                    sdo_q   <= 1'b0;
                end
            endcase
        end
    end

    assign sdo_out = sdo_q;

    logic unused_ok;
    assign unused_ok = ^smp_prev;

endmodule

// File: rtl/sadc_emu_chk.sv
module sadc_emu_chk (
    input logic              clk,
    input logic              rst,
    input sadc_pkg::phase_t  phase_q,
    input logic              cs_lvl,
    input logic              sclk_fall,
    input logic              tmr_done,
    input logic              shf_msb,
    input logic              sdo_out
);
    import sadc_pkg::*;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        phase_q == PH_IDLE |-> !sdo_out);

    // R1
    cs_high_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_lvl |=> phase_q == PH_IDLE);

    // R3
    conv_low_chk: assert property (@(posedge clk) disable iff (rst)
        phase_q == PH_CONV |-> !sdo_out);

    // R3
    eoc_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_READ && $past(phase_q) == PH_CONV) |-> sdo_out);

    // R4
    conv_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CONV && !tmr_done && !cs_lvl) |=> phase_q == PH_CONV);

    // R5
    shift_out_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_READ && sclk_fall && !cs_lvl) |=> sdo_out == $past(shf_msb));

    // R6
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_READ && !sclk_fall && !cs_lvl) |=> $stable(sdo_out));

endmodule

bind sadc_emu sadc_emu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .phase_q   (phase_q),
    .cs_lvl    (cs_lvl),
    .sclk_fall (sclk_fall),
    .tmr_done  (tmr_done),
    .shf_msb   (shf_msb),
    .sdo_out   (sdo_out)
);

// File: tb/sadc_emu_bench.sv
module sadc_emu_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CONV       = 12;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic [11:0] smp = '0;
    logic        sdo;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sadc_emu #(.CONV_CYCLES(CONV)) u_sadc_emu (
        .clk       (clk),
        .rst       (rst),
        .cs_n_in   (cs_n),
        .sclk_in   (sclk),
        .sample_in (smp),
        .sdo_out   (sdo)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: input history queues plus a phase integer
    logic cq[$];
    logic kq[$];
    logic [11:0] wq[$];
    int   m_ph, m_cnt, m_nb;
    logic m_sdo;
    logic [11:0] m_word;

    always @(posedge clk) begin
        if (rst) begin
            cq = '{1'b1, 1'b1, 1'b1};
            kq = '{1'b0, 1'b0, 1'b0};
            wq = '{12'h0, 12'h0, 12'h0};
            m_ph = 0; m_cnt = 0; m_nb = 0; m_sdo = 1'b0; m_word = '0;
        end else begin
            if (cq[1]) begin
                m_ph = 0; m_sdo = 1'b0;
            end else begin
                case (m_ph)
                    0: if (cq[2]) begin m_ph = 1; m_cnt = 0; m_word = wq[1]; end
                    1: begin
                        if (m_cnt == CONV - 1) begin m_ph = 2; m_sdo = 1'b1; m_nb = 0; end
                        else m_cnt++;
                    end
                    default: if (kq[2] && !kq[1]) begin
                        m_sdo = (m_nb < 12) ? m_word[11 - m_nb] : 1'b0;
                        m_nb++;
                    end
                endcase
            end
            cq.push_front(cs_n); void'(cq.pop_back());
            kq.push_front(sclk); void'(kq.pop_back());
            wq.push_front(smp);  void'(wq.pop_back());
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            string tag;
            if (m_ph == 0)      tag = "R1";
            else if (m_ph == 1) tag = "R3 R4";
            else if (m_nb == 0) tag = "R3";
            else if (m_nb <= 12) tag = "R5";
            else                tag = "R7";
            chk(sdo === m_sdo, tag, int'(sdo), int'(m_sdo));
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_and_time(output int lat);
        @(negedge clk);
        cs_n = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (sdo !== 1'b1 && lat < 1000);
    endtask

    task automatic read_frame(input int nclk, output logic [11:0] word, output int extra_ones);
        word = '0;
        extra_ones = 0;
        for (int i = 0; i < nclk; i++) begin
            @(negedge clk);
            if (i >= 1) begin
                if (i - 1 < 12) word[12 - i] = sdo;
                else if (sdo) extra_ones++;
            end
            sclk = 1'b1;
            wait_n(HALF);
            sclk = 1'b0;
            wait_n(HALF);
        end
    endtask

    task automatic end_frame();
        @(negedge clk);
        cs_n = 1'b1;
        wait_n(6);
    endtask

    initial begin
        int lat, ones;
        logic [11:0] w;
        wait_n(5);
        chk(sdo === 1'b0, "R1", int'(sdo), 0);
        rst = 1'b0;
        wait_n(4);

        // frame 1: plain read with trailing clocks
        smp = 12'hA5C;
        wait_n(4);
        start_and_time(lat);
        chk(lat == CONV + 3, "R9", lat, CONV + 3);
        read_frame(15, w, ones);
        chk(w == 12'hA5C, "R2", int'(w), 12'hA5C);
        chk(ones == 0, "R7", ones, 0);
        end_frame();
        chk(sdo === 1'b0, "R1", int'(sdo), 0);

        // frame 2: serial clock toggles during conversion
        smp = 12'hFFF;
        wait_n(4);
        @(negedge clk);
        cs_n = 1'b0;
        for (int j = 0; j < 2; j++) begin
            wait_n(2); sclk = 1'b1;
            wait_n(2); sclk = 1'b0;
        end
        lat = 8;
        while (sdo !== 1'b1 && lat < 1000) begin @(negedge clk); lat++; end
        chk(lat == CONV + 3, "R4", lat, CONV + 3);
        read_frame(13, w, ones);
        chk(w == 12'hFFF, "R4", int'(w), 12'hFFF);
        end_frame();

        // frame 3: abort partway through readout
        smp = 12'h801;
        wait_n(4);
        start_and_time(lat);
        read_frame(5, w, ones);
        end_frame();
        chk(sdo === 1'b0, "R8", int'(sdo), 0);
        smp = 12'h3C5;
        wait_n(4);
        start_and_time(lat);
        chk(lat == CONV + 3, "R8", lat, CONV + 3);
        read_frame(14, w, ones);
        chk(w == 12'h3C5, "R8", int'(w), 12'h3C5);
        chk(ones == 0, "R7", ones, 0);
        end_frame();

        // frame 4: abort during conversion, no flag must follow
        smp = 12'h6B2;
        wait_n(4);
        @(negedge clk);
        cs_n = 1'b0;
        wait_n(6);
        cs_n = 1'b1;
        ones = 0;
        for (int j = 0; j < 3 * CONV; j++) begin
            @(negedge clk);
            if (sdo) ones++;
        end
        chk(ones == 0, "R8", ones, 0);
        start_and_time(lat);
        chk(lat == CONV + 3, "R9", lat, CONV + 3);
        read_frame(12, w, ones);
        chk(w == 12'h6B2, "R2", int'(w), 12'h6B2);
        end_frame();

        // frame 5: extreme words, zero result
        smp = 12'h000;
        wait_n(4);
        start_and_time(lat);
        read_frame(16, w, ones);
        chk(w == 12'h000, "R5", int'(w), 0);
        chk(ones == 0, "R7", ones, 0);
        end_frame();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule